// File: doc/BRIEF.md
# Hardware Stack Pointer Unit

This block keeps an 8-bit stack pointer and the 256-byte internal memory that holds the stack. A producer pushes bytes through a valid/ready port. A consumer asks for pops through a second valid/ready port, and each popped byte comes back on a data output one cycle later. A plain load strobe writes the pointer directly, so software can move the stack, usually into the upper half of the memory.

The pointer starts at 07h.

- A push first increments the pointer, then stores the byte at the new pointer, so the first byte after reset lands at 08h.
- A pop reads the byte at the current pointer, then decrements the pointer.

The memory address and write enable for the current cycle are shown on output pins.

Wrapping in either direction is allowed. Each wrap is flagged by a one-cycle status pulse.

Back-pressure rules:

- The push port is ready whenever no pop is requested and no load is applied.
- The pop port is ready whenever no push is requested and no load is applied.
- A transfer happens when valid and ready are both high at a clock edge. So when push and pop are requested together, both are refused.
- The popped-data output has no ready. The consumer must take it in the cycle in which its valid is high.

Top module: `stack_ptr_unit`

## Requirements
- R1: After reset the pointer reads 07h, and the popped-data valid, overflow and underflow outputs are low.
- R2: An accepted push, with the pointer at S, drives the memory address to S+1 and the write enable high in that cycle. The byte is stored at S+1 and the pointer reads S+1 from the next cycle.
- R3: An accepted pop, with the pointer at S, returns the byte stored at S on the popped-data output. The popped-data valid is high for exactly the next cycle, and the pointer reads S-1 from that cycle.
- R4: Bytes pushed in a sequence come back in reverse order when popped.
- R5: A load strobe sets the pointer to the load value from the next cycle. While the strobe is high both ready outputs are low, and no push or pop takes effect.
- R6: A push accepted at pointer FFh wraps the pointer to 00h. The overflow output is then high for exactly one cycle; otherwise it is low.
- R7: A pop accepted at pointer 00h wraps the pointer to FFh. The underflow output is then high for exactly one cycle; otherwise it is low.
- R8: When push and pop are requested in the same cycle, both ready outputs are low. The pointer and the memory contents are left unchanged.
- R9: In any cycle without an accepted push, the write enable is low and the memory address equals the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Push request |
| push_ready | output | 1 | Push can be taken this cycle |
| push_data | input | 8 | Byte to push |
| pop_valid | input | 1 | Pop request |
| pop_ready | output | 1 | Pop can be taken this cycle |
| pop_data_valid | output | 1 | Popped byte present |
| pop_data | output | 8 | Popped byte |
| sp_load | input | 1 | Direct pointer write strobe |
| sp_load_value | input | 8 | Value for direct pointer write |
| sp | output | 8 | Current stack pointer |
| ram_addr | output | 8 | Memory address for this cycle |
| ram_we | output | 1 | Memory write enable for this cycle |
| overflow | output | 1 | One-cycle pulse after a push wraps |
| underflow | output | 1 | One-cycle pulse after a pop wraps |

## Verification
The ready outputs, memory address and write enable follow the inputs within the same cycle. The bench compares them shortly after driving the inputs, before the clock edge. The pointer, popped data with its valid, and both wrap pulses are due one cycle after the request. The bench compares them at the falling edge that follows the accepting rising edge, against a behavioural model that it updates at that same edge. Popped data is compared only for addresses the model knows were written.

// File: rtl/stkp_pkg.sv
package stkp_pkg;
  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_PUSH  = 3'd1,
    OP_POP   = 3'd2,
    OP_LOAD  = 3'd3,
    OP_CLASH = 3'd4
  } stk_op_e;
endpackage

// File: rtl/stkp_arbiter.sv
module stkp_arbiter
  import stkp_pkg::*;
(
  input  logic    push_valid,
  input  logic    pop_valid,
  input  logic    sp_load,
  output logic    push_ready,
  output logic    pop_ready,
  output stk_op_e op
);
  always_comb begin
    push_ready = !pop_valid && !sp_load;
    pop_ready  = !push_valid && !sp_load;
    if (sp_load)                      op = OP_LOAD;
    else if (push_valid && pop_valid) op = OP_CLASH;
    else if (push_valid)              op = OP_PUSH;
    else if (pop_valid)               op = OP_POP;
    else                              op = OP_IDLE;
  end
endmodule

// File: rtl/stkp_pointer.sv
module stkp_pointer
  import stkp_pkg::*;
#(
  parameter int unsigned PTR_W = 8,
  parameter logic [PTR_W-1:0] RESET_SP = 8'h07
) (
  input  logic             clk,
  input  logic             rst_n,
  input  stk_op_e          op,
  input  logic [PTR_W-1:0] load_value,
  output logic [PTR_W-1:0] sp,
  output logic [PTR_W-1:0] sp_inc,
  output logic             ovf_pulse,
  output logic             unf_pulse
);
  localparam logic [PTR_W-1:0] TOP = {PTR_W{1'b1}};
  localparam logic [PTR_W-1:0] BOT = {PTR_W{1'b0}};
  localparam logic [PTR_W-1:0] ONE = {{(PTR_W-1){1'b0}}, 1'b1};

  logic [PTR_W-1:0] sp_dec;
  logic [PTR_W-1:0] sp_nxt;

  always_comb begin
    sp_inc = sp + ONE;
    sp_dec = sp - ONE;
    case (op)
      OP_LOAD: sp_nxt = load_value;
      OP_PUSH: sp_nxt = sp_inc;
      OP_POP:  sp_nxt = sp_dec;
      default: sp_nxt = sp;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp        <= RESET_SP;
      ovf_pulse <= 1'b0;
      unf_pulse <= 1'b0;
    end else begin
      sp        <= sp_nxt;
      ovf_pulse <= (op == OP_PUSH) && (sp == TOP);
      unf_pulse <= (op == OP_POP) && (sp == BOT);
    end
  end
endmodule

// File: rtl/stkp_ram.sv
module stkp_ram #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rvalid <= 1'b0;
    else        rvalid <= re;
  end
endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
  import stkp_pkg::*;
#(
  parameter int unsigned PTR_W  = 8,
  parameter int unsigned DATA_W = 8,
  parameter logic [PTR_W-1:0] RESET_SP = 8'h07
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  output logic              push_ready,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_valid,
  output logic              pop_ready,
  output logic              pop_data_valid,
  output logic [DATA_W-1:0] pop_data,
  input  logic              sp_load,
  input  logic [PTR_W-1:0]  sp_load_value,
  output logic [PTR_W-1:0]  sp,
  output logic [PTR_W-1:0]  ram_addr,
  output logic              ram_we,
  output logic              overflow,
  output logic              underflow
);
  stk_op_e          op;
  logic [PTR_W-1:0] sp_inc;

  stkp_arbiter u_arb (
    .push_valid (push_valid),
    .pop_valid  (pop_valid),
    .sp_load    (sp_load),
    .push_ready (push_ready),
    .pop_ready  (pop_ready),
    .op         (op)
  );

  stkp_pointer #(.PTR_W(PTR_W), .RESET_SP(RESET_SP)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .op         (op),
    .load_value (sp_load_value),
    .sp         (sp),
    .sp_inc     (sp_inc),
    .ovf_pulse  (overflow),
    .unf_pulse  (underflow)
  );

  always_comb begin
    ram_we   = (op == OP_PUSH);
    ram_addr = ram_we ? sp_inc : sp;
  end

  stkp_ram #(.ADDR_W(PTR_W), .DATA_W(DATA_W)) u_ram (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (ram_we),
    .re     (op == OP_POP),
    .addr   (ram_addr),
    .wdata  (push_data),
    .rdata  (pop_data),
    .rvalid (pop_data_valid)
  );
endmodule

// File: rtl/stack_ptr_unit_chk.sv
module stack_ptr_unit_chk #(
  parameter int unsigned PTR_W  = 8,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              push_valid,
  input logic              push_ready,
  input logic              pop_valid,
  input logic              pop_ready,
  input logic              pop_data_valid,
  input logic              sp_load,
  input logic [PTR_W-1:0]  sp_load_value,
  input logic [PTR_W-1:0]  sp,
  input logic [PTR_W-1:0]  ram_addr,
  input logic              ram_we,
  input logic              overflow,
  input logic              underflow
);
  localparam logic [PTR_W-1:0] ONE = {{(PTR_W-1){1'b0}}, 1'b1};

  // R2
  p_push_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && push_ready) |=> (sp == PTR_W'($past(sp) + ONE)));

  // R3
  p_pop_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_valid && pop_ready) |=> (pop_data_valid && sp == PTR_W'($past(sp) - ONE)));

  // R3
  p_pop_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop_valid && pop_ready) |=> !pop_data_valid);

  // R5
  p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sp_load |=> (sp == $past(sp_load_value)));

  // R5
  p_load_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sp_load |-> (!push_ready && !pop_ready && !ram_we));

  // R6
  p_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && push_ready && sp == {PTR_W{1'b1}}) |=> overflow);

  // R6
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_valid && push_ready && sp == {PTR_W{1'b1}}) |=> !overflow);

  // R7
  p_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_valid && pop_ready && sp == {PTR_W{1'b0}}) |=> underflow);

  // R7
  p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop_valid && pop_ready && sp == {PTR_W{1'b0}}) |=> !underflow);

  // R8
  p_clash_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && pop_valid && !sp_load) |=> $stable(sp));

  // R9
  p_we_only_push_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (push_valid && push_ready));

  // R9
  p_idle_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_valid && push_ready) |-> (ram_addr == sp && !ram_we));
endmodule

bind stack_ptr_unit stack_ptr_unit_chk #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .push_valid     (push_valid),
  .push_ready     (push_ready),
  .pop_valid      (pop_valid),
  .pop_ready      (pop_ready),
  .pop_data_valid (pop_data_valid),
  .sp_load        (sp_load),
  .sp_load_value  (sp_load_value),
  .sp             (sp),
  .ram_addr       (ram_addr),
  .ram_we         (ram_we),
  .overflow       (overflow),
  .underflow      (underflow)
);

// File: tb/stack_ptr_unit_test.sv
`timescale 1ns/1ps
module stack_ptr_unit_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       push_valid = 1'b0;
  logic       push_ready;
  logic [7:0] push_data = 8'h00;
  logic       pop_valid = 1'b0;
  logic       pop_ready;
  logic       pop_data_valid;
  logic [7:0] pop_data;
  logic       sp_load = 1'b0;
  logic [7:0] sp_load_value = 8'h00;
  logic [7:0] sp;
  logic [7:0] ram_addr;
  logic       ram_we;
  logic       overflow;
  logic       underflow;

  int n_vec = 0;
  int n_bad = 0;

  int m_sp;
  int m_mem [256];
  bit m_known [256];
  int m_pdata;
  bit m_pvalid;
  bit m_pknown;
  bit m_ovf;
  bit m_unf;

  always #10 clk = ~clk;

  stack_ptr_unit uut (
    .clk(clk), .rst_n(rst_n),
    .push_valid(push_valid), .push_ready(push_ready), .push_data(push_data),
    .pop_valid(pop_valid), .pop_ready(pop_ready),
    .pop_data_valid(pop_data_valid), .pop_data(pop_data),
    .sp_load(sp_load), .sp_load_value(sp_load_value),
    .sp(sp), .ram_addr(ram_addr), .ram_we(ram_we),
    .overflow(overflow), .underflow(underflow)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // Drive one cycle; called at a falling edge, returns at the next one.
  task automatic step(input bit pu, input bit po, input bit ld,
                      input int lv, input int d, input string tag);
    bit acc_push, acc_pop;
    push_valid = pu; pop_valid = po; sp_load = ld;
    sp_load_value = 8'(lv); push_data = 8'(d);
    acc_push = pu && !po && !ld;
    acc_pop  = po && !pu && !ld;
    #2;
    chk({tag, " R9/R8/R5 push_ready"}, int'(push_ready), int'(!po && !ld));
    chk({tag, " R9/R8/R5 pop_ready"}, int'(pop_ready), int'(!pu && !ld));
    chk({tag, " R2/R9 ram_we"}, int'(ram_we), int'(acc_push));
    chk({tag, " R2/R9 ram_addr"}, int'(ram_addr), acc_push ? ((m_sp + 1) % 256) : m_sp);
    @(posedge clk);
    m_pvalid = acc_pop;
    m_ovf = acc_push && (m_sp == 255);
    m_unf = acc_pop && (m_sp == 0);
    if (acc_pop) begin
      m_pdata = m_mem[m_sp];
      m_pknown = m_known[m_sp];
    end
    if (ld) m_sp = lv % 256;
    else if (acc_push) begin
      m_sp = (m_sp + 1) % 256;
      m_mem[m_sp] = d % 256;
      m_known[m_sp] = 1'b1;
    end else if (acc_pop) m_sp = (m_sp + 255) % 256;
    @(negedge clk);
    chk({tag, " R2/R3/R5 sp"}, int'(sp), m_sp);
    chk({tag, " R3 pop_data_valid"}, int'(pop_data_valid), int'(m_pvalid));
    chk({tag, " R6 overflow"}, int'(overflow), int'(m_ovf));
    chk({tag, " R7 underflow"}, int'(underflow), int'(m_unf));
    if (m_pvalid && m_pknown) chk({tag, " R3/R4 pop_data"}, int'(pop_data), m_pdata);
    push_valid = 1'b0; pop_valid = 1'b0; sp_load = 1'b0;
  endtask

  initial begin
    #4_000_000;
    n_vec++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] lfsr;
    m_sp = 7; m_pvalid = 0; m_ovf = 0; m_unf = 0; m_pknown = 0; m_pdata = 0;
    for (int i = 0; i < 256; i++) begin m_mem[i] = 0; m_known[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 sp", int'(sp), 7);
    chk("R1 pop_data_valid", int'(pop_data_valid), 0);
    chk("R1 overflow", int'(overflow), 0);
    chk("R1 underflow", int'(underflow), 0);
    // R2 first push at 08h, R4 LIFO
    step(1, 0, 0, 0, 8'hA1, "push1");
    chk("R2 first byte at 08h", int'(sp), 8);
    step(1, 0, 0, 0, 8'hB2, "push2");
    step(1, 0, 0, 0, 8'hC3, "push3");
    step(0, 0, 0, 0, 0, "idle");
    step(0, 1, 0, 0, 0, "pop3");
    chk("R4 last in first out", int'(pop_data), 8'hC3);
    step(0, 1, 0, 0, 0, "pop2");
    chk("R4 second out", int'(pop_data), 8'hB2);
    // R8 clash: nothing changes; the following pop must still return A1
    step(1, 1, 0, 0, 8'h5A, "clash");
    step(0, 1, 0, 0, 0, "pop1");
    chk("R8 memory untouched by clash", int'(pop_data), 8'hA1);
    // R5 relocate and load priority
    step(1, 0, 1, 8'h80, 8'h77, "load80");
    chk("R5 load value", int'(sp), 8'h80);
    step(1, 0, 0, 0, 8'h11, "push81");
    step(0, 1, 1, 8'h81, 0, "load_over_pop");
    chk("R5 pop blocked by load", int'(pop_data_valid), 0);
    step(0, 1, 0, 0, 0, "pop81");
    chk("R3 relocated pop", int'(pop_data), 8'h11);
    // R6 wrap on push
    step(0, 0, 1, 8'hFF, 0, "loadFF");
    step(1, 0, 0, 0, 8'h3C, "push_wrap");
    chk("R6 wrapped sp", int'(sp), 0);
    chk("R6 overflow pulse", int'(overflow), 1);
    step(0, 0, 0, 0, 0, "after_wrap");
    chk("R6 pulse one cycle", int'(overflow), 0);
    // R7 wrap on pop (sp=00 holds 3C)
    step(0, 1, 0, 0, 0, "pop_wrap");
    chk("R7 wrapped sp", int'(sp), 8'hFF);
    chk("R7 underflow pulse", int'(underflow), 1);
    chk("R7 popped data", int'(pop_data), 8'h3C);
    step(0, 0, 0, 0, 0, "after_unf");
    chk("R7 pulse one cycle", int'(underflow), 0);
    // mixed pattern
    lfsr = 8'h5D;
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(lfsr[0], lfsr[1] & ~lfsr[2], (lfsr[7:4] == 4'hF), int'(lfsr ^ 8'hC5),
           int'(lfsr), "mix");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule